// File: doc/BRIEF.md
# Master-Slave Frame Sync Sequencer

This block times a chain of serial codecs that share one serial port. One master device and up to three slave devices take turns on the port in time-division slots. The block divides the master clock by four to make the shift clock, and in every sampling period it drives one active-low frame sync per device. The master's sync comes first. Each slave's sync follows the previous one after a programmable delay of FSD shift clocks.

A second round of syncs, used to reach the codec control registers, is inserted at the midpoint of the sampling period. The round goes ahead only if every enabled device asked for it. A device asks by carrying the value 11 in the two low bits of the word sent during its primary slot, and that value is presented on `sec_req_i`. The block raises a flag while the frames of the second round are on the port. It reports an error when the programmed slot spacing is below the legal minimum or when the slots cannot fit in half a period.

Top module: `fs_seq`

## Requirements
- R1: `sclk_o` is low after reset and has a period of four `clk_i` cycles: two cycles low, then two cycles high. It falls on every fourth `clk_i` edge.
- R2: While `rst_ni` is low, all `fs_n_o` bits are high and `sclk_o`, `sec_o` are low.
- R3: One sampling period lasts P = A·B/2 shift clocks. The master sync `fs_n_o[0]` is low for exactly the first shift clock of every period, starting with the first shift clock after reset.
- R4: Slave k (bit k of `fs_n_o`, 1 ≤ k ≤ `slave_cnt_i`) goes low for one shift clock at offset k·FSD. Bits above `slave_cnt_i` stay high at all times.
- R5: A second round runs when every enabled device presented `sec_req_i` = 2'b11 during its own primary sync shift clock. In that round the master sync is low at offset H = A·B/4 and slave k is low at H + k·FSD, all within the same period.
- R6: `sec_req_i` is ignored outside the primary sync shift clocks. If any enabled device presents a value other than 2'b11 in its primary slot, no second round occurs in that period.
- R7: `sec_o` is high from the shift clock of the master's second-round sync up to the end of that period, and low otherwise.
- R8: `err_o` is high when FSD < 18 or when (`slave_cnt_i`+1)·FSD > H. While it is high, no second round runs and no primary sync is issued at an offset of H or later.
- R9: At most one `fs_n_o` bit is low at any time. `fs_n_o` and `sec_o` change only at the `clk_i` edge on which `sclk_o` falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| a_val_i | input | 8 | Divider value A |
| b_val_i | input | 8 | Divider value B |
| fsd_i | input | 8 | Sync spacing in shift clocks |
| slave_cnt_i | input | 2 | Number of slaves in the chain |
| sec_req_i | input | 2 | Low two bits of the current primary transmit word |
| sclk_o | output | 1 | Shift clock, master clock / 4 |
| fs_n_o | output | 4 | Active-low frame sync per device, bit 0 is the master |
| sec_o | output | 1 | High during second-round frames |
| err_o | output | 1 | Slot spacing or fit violation |

## Verification
The sync lines and `sec_o` are registered on the master-clock edge that ends a shift clock. The state of shift clock s therefore appears after the master-clock edge numbered 4(s+1), counting from the release of reset. The bench waits four falling edges for each shift clock and compares the sync vector there. It samples `sclk_o` on every falling edge, and `err_o`, which follows the configuration combinationally, right after reset is released. The request value for a slot is driven on the falling edge that opens that slot and is taken at the edge that closes it, so its effect on the second round is checked at offset H of the same period.

// File: rtl/fs_pkg.sv
package fs_pkg;
  localparam int unsigned MIN_FSD = 18;
  localparam logic [1:0]  SEC_REQ = 2'b11;
endpackage

// File: rtl/fs_clk_div.sv
module fs_clk_div #(
  parameter int unsigned DIV_W = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  output logic sclk_o,
  output logic tick_o
);
  logic [DIV_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '0;
    else         cnt_q <= cnt_q + 1'b1;
  end

  assign sclk_o = cnt_q[DIV_W-1];
  assign tick_o = &cnt_q;

  // R1
  sclk_fall_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sclk_o) |-> $past(tick_o));
endmodule

// File: rtl/fs_period_cnt.sv
module fs_period_cnt #(
  parameter int unsigned A_W    = 8,
  parameter int unsigned B_W    = 8,
  localparam int unsigned PROD_W = A_W + B_W
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic [A_W-1:0]    a_i,
  input  logic [B_W-1:0]    b_i,
  output logic [PROD_W-1:0] pos_o,
  output logic [PROD_W-1:0] pos_nxt_o,
  output logic [PROD_W-1:0] half_o
);
  logic [PROD_W-1:0] prod, per, pos_q;

  assign prod      = PROD_W'(a_i) * PROD_W'(b_i);
  assign per       = prod >> 1;
  assign half_o    = prod >> 2;
  // reset value wraps to slot 0 on the first tick
  assign pos_nxt_o = (pos_q >= per - 1'b1) ? '0 : pos_q + 1'b1;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)     pos_q <= '1;
    else if (tick_i) pos_q <= pos_nxt_o;
  end

  assign pos_o = pos_q;

  // R3
  pos_range_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    tick_i |=> (pos_q < per));
endmodule

// File: rtl/fs_slot_dec.sv
module fs_slot_dec #(
  parameter int unsigned N_DEV  = 4,
  parameter int unsigned PROD_W = 16,
  parameter int unsigned FSD_W  = 8,
  parameter int unsigned CNT_W  = 2
) (
  input  logic [PROD_W-1:0] pos_i,
  input  logic [PROD_W-1:0] half_i,
  input  logic [FSD_W-1:0]  fsd_i,
  input  logic [CNT_W-1:0]  cnt_i,
  input  logic              sec_en_i,
  output logic [N_DEV-1:0]  fire_o
);
  for (genvar k = 0; k < N_DEV; k++) begin : g_dev
    logic [PROD_W-1:0] off;
    logic pri_hit, sec_hit, enabled;
    assign off     = PROD_W'(k) * PROD_W'(fsd_i);
    assign enabled = ({1'b0, cnt_i} >= (CNT_W+1)'(k));
    assign pri_hit = (off < half_i) && (pos_i == off);
    assign sec_hit = sec_en_i && (pos_i == half_i + off);
    assign fire_o[k] = enabled && (pri_hit || sec_hit);
  end
endmodule

// File: rtl/fs_seq.sv
module fs_seq #(
  parameter int unsigned A_W        = 8,
  parameter int unsigned B_W        = 8,
  parameter int unsigned FSD_W      = 8,
  parameter int unsigned MAX_SLAVES = 3,
  localparam int unsigned N_DEV     = MAX_SLAVES + 1,
  localparam int unsigned CNT_W     = $clog2(N_DEV),
  localparam int unsigned PROD_W    = A_W + B_W
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [A_W-1:0]   a_val_i,
  input  logic [B_W-1:0]   b_val_i,
  input  logic [FSD_W-1:0] fsd_i,
  input  logic [CNT_W-1:0] slave_cnt_i,
  input  logic [1:0]       sec_req_i,
  output logic             sclk_o,
  output logic [N_DEV-1:0] fs_n_o,
  output logic             sec_o,
  output logic             err_o
);
  import fs_pkg::*;

  logic              tick;
  logic [PROD_W-1:0] pos_q, pos_nxt, half, need;
  logic [N_DEV-1:0]  fire, fs_n_q;
  logic              req_and_q, req_and_d, sec_q, sec_d, pri_slot;

  fs_clk_div #(.DIV_W(2)) u_div (
    .clk_i(clk_i), .rst_ni(rst_ni), .sclk_o(sclk_o), .tick_o(tick));

  fs_period_cnt #(.A_W(A_W), .B_W(B_W)) u_per (
    .clk_i(clk_i), .rst_ni(rst_ni), .tick_i(tick), .a_i(a_val_i), .b_i(b_val_i),
    .pos_o(pos_q), .pos_nxt_o(pos_nxt), .half_o(half));

  assign need  = PROD_W'({1'b0, slave_cnt_i} + 1'b1) * PROD_W'(fsd_i);
  assign err_o = (fsd_i < FSD_W'(MIN_FSD)) || (need > half);

  // request sampled at the tick closing a primary sync slot
  assign pri_slot  = (pos_q < half) && !(&fs_n_q);
  assign req_and_d = (pos_nxt == '0) ? 1'b1
                   : req_and_q & (!pri_slot || (sec_req_i == SEC_REQ));
  assign sec_d     = (pos_nxt == '0)  ? 1'b0
                   : (pos_nxt == half) ? (req_and_d && !err_o)
                   : sec_q;

  fs_slot_dec #(.N_DEV(N_DEV), .PROD_W(PROD_W), .FSD_W(FSD_W), .CNT_W(CNT_W)) u_dec (
    .pos_i(pos_nxt), .half_i(half), .fsd_i(fsd_i), .cnt_i(slave_cnt_i),
    .sec_en_i(sec_d), .fire_o(fire));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      fs_n_q    <= '1;
      req_and_q <= 1'b1;
      sec_q     <= 1'b0;
    end else if (tick) begin
      fs_n_q    <= ~fire;
      req_and_q <= req_and_d;
      sec_q     <= sec_d;
    end
  end

  assign fs_n_o = fs_n_q;
  assign sec_o  = sec_q;

  // R9
  one_fs_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(~fs_n_o));
  // R9
  fs_edge_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !$stable(fs_n_o) |-> $past(tick));
  // R7
  sec_rise_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sec_o) |-> !fs_n_o[0]);
  // R8
  err_no_sec_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    err_o |-> !sec_o);
  for (genvar k = 1; k < N_DEV; k++) begin : g_cnt_chk
    // R4
    unused_dev_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !fs_n_o[k] |-> ({1'b0, slave_cnt_i} >= (CNT_W+1)'(k)));
  end
endmodule

// File: tb/fs_seq_test.sv
module fs_seq_test;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 200000;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] a_val_i = 8'd16, b_val_i = 8'd18, fsd_i = 8'd18;
  logic [1:0] slave_cnt_i = 2'd3, sec_req_i = 2'd0;
  logic       sclk_o, sec_o, err_o;
  logic [3:0] fs_n_o;

  int checks = 0, failures = 0;
  bit done = 0;

  fs_seq uut (
    .clk_i(clk_i), .rst_ni(rst_ni), .a_val_i(a_val_i), .b_val_i(b_val_i),
    .fsd_i(fsd_i), .slave_cnt_i(slave_cnt_i), .sec_req_i(sec_req_i),
    .sclk_o(sclk_o), .fs_n_o(fs_n_o), .sec_o(sec_o), .err_o(err_o));

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s act=%0h exp=%0h", tag, what, act, exp);
    end
  endtask

  function automatic bit exp_err(int fsd, int n, int h);
    return (fsd < 18) || ((n + 1) * fsd > h);
  endfunction

  function automatic logic [3:0] exp_fire(int pos, int h, int fsd, int n, bit sa);
    logic [3:0] v = '0;
    for (int k = 0; k < 4; k++) begin
      if (k <= n) begin
        if ((k * fsd < h) && (pos == k * fsd)) v[k] = 1'b1;
        if (sa && (pos == h + k * fsd))        v[k] = 1'b1;
      end
    end
    return v;
  endfunction

  task automatic run_cfg(input int a, input int b, input int n, input int fsd,
                         input int periods);
    int per = a * b / 2;
    int h = a * b / 4;
    bit err = exp_err(fsd, n, h);
    bit racc = 1, sa = 0;
    int mode = 0, bad_k = 0;
    logic [3:0] last_fs = '1;
    @(negedge clk_i);
    rst_ni = 1'b0;
    a_val_i = 8'(a); b_val_i = 8'(b); fsd_i = 8'(fsd); slave_cnt_i = 2'(n);
    repeat (3) @(negedge clk_i);
    // R2 reset state
    chk(fs_n_o == 4'hf && !sclk_o && !sec_o, "R2", "reset outputs",
        {fs_n_o, sclk_o, sec_o}, {4'hf, 2'b00});
    rst_ni = 1'b1;
    #1;
    chk(err_o == err, "R8", "err_o", err_o, err);
    for (int s = 0; s < periods * per; s++) begin
      for (int j = 1; j <= 4; j++) begin
        @(negedge clk_i);
        chk(sclk_o == (j == 2 || j == 3), "R1", "sclk_o", sclk_o, (j == 2 || j == 3));
        // R9: no change within a shift clock
        if (j < 4 && s > 0) chk(fs_n_o == last_fs, "R9", "fs mid-slot", fs_n_o, last_fs);
      end
      begin
        int pos = s % per;
        logic [3:0] ef;
        string tag;
        if (pos == 0) begin
          racc = 1; sa = 0;
          mode = $urandom % 3;
          bad_k = $urandom % (n + 1);
        end
        if (pos == h) sa = racc && !err;
        ef = exp_fire(pos, h, fsd, n, sa);
        tag = (pos >= h) ? ((mode != 0) ? "R6" : "R5") : ((pos == 0) ? "R3" : "R4");
        if (err && pos >= h) tag = "R8";
        chk(fs_n_o == ~ef, tag, "fs_n_o", fs_n_o, ~ef);
        chk(sec_o == (sa && pos >= h), "R7", "sec_o", sec_o, (sa && pos >= h));
        chk($countones(~fs_n_o) <= 1, "R9", "sync overlap", fs_n_o, 1);
        last_fs = fs_n_o;
        // drive request for this slot; outside primary slots it is noise (R6)
        if (pos < h && ef != 0) begin
          int k = 0;
          for (int i = 0; i < 4; i++) if (ef[i]) k = i;
          case (mode)
            0: sec_req_i = 2'b11;
            1: sec_req_i = 2'($urandom % 4);
            default: sec_req_i = (k == bad_k) ? 2'($urandom % 3) : 2'b11;
          endcase
          racc = racc && (sec_req_i == 2'b11);
        end else begin
          sec_req_i = 2'($urandom % 4);
        end
      end
    end
  endtask

  initial begin
    void'($urandom(32'd20240611));
    // directed corners
    run_cfg(16, 18, 3, 18, 3); // slots exactly fill half period
    run_cfg(16, 18, 3, 19, 2); // fit violation
    run_cfg(12, 16, 3, 20, 2); // last primary past midpoint suppressed
    run_cfg(16, 18, 1, 17, 2); // spacing below minimum
    run_cfg(8, 20, 0, 25, 4);  // master only
    run_cfg(12, 16, 1, 20, 4);
    // random configs
    for (int r = 0; r < 4; r++) begin
      int a = 2 * (4 + $urandom % 7);
      int b = 2 * (4 + $urandom % 7);
      run_cfg(a, b, $urandom % 4, 17 + $urandom % 8, 3);
    end
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (WATCHDOG) @(posedge clk_i);
    if (!done) begin
      failures++;
      $display("FAIL watchdog expired act=0 exp=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule